// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line in a small private cache. The cache sits on a shared snooping bus. Each line is in one of four states: Invalid, Shared, Exclusive or Modified. The states are kept in a register array indexed by line number. Two kinds of event change a state:

- requests from the block's own core: read, write or evict;
- commands that other caches place on the bus and that this block snoops: read, write or upgrade.

For each event the block does two things. It moves the line to its next state. It also emits one of the following, or nothing:

- an outgoing bus command;
- a shared or dirty snoop response;
- a writeback request;
- an illegal-snoop error pulse.

Local requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in every cycle where `snp_valid` is high, because snoops cannot be stalled and so take priority. While `req_valid` is high and `req_ready` is low, the core must hold `req_op`, `req_idx` and `req_shared` stable.

For a local read miss, `req_shared` gives the sharing result of the bus read and is sampled with the request. All outputs come from registers and appear in the cycle after the event is taken. Each output lasts one cycle. A separate lookup port returns the current state of any line combinationally, so the core can test for a hit.

Top module: `mesi_snoop_ctrl`

Encodings used throughout:

| Signal | Values |
|---|---|
| line state | 0 = Invalid, 1 = Shared, 2 = Exclusive, 3 = Modified |
| `req_op` | 0 = read, 1 = write, 2 = evict; code 3 has no effect |
| `snp_cmd` | 0 = read, 1 = write, 2 = upgrade; code 3 has no effect |
| `bus_cmd` | 0 = read, 1 = write, 2 = upgrade |

## Requirements
- R1: After reset every line reads back as Invalid (0), and `bus_valid`, `wb_valid`, `resp_shared`, `resp_dirty` and `err_illegal` are all 0.
- R2: A local read (`req_op` 0) of an Invalid line issues bus command 0 on the next cycle. The line becomes Exclusive (2) when `req_shared` is 0 and Shared (1) when `req_shared` is 1.
- R3: A local write (`req_op` 1) of an Invalid line issues bus command 1 and the line becomes Modified (3).
- R4: A local write of a Shared line issues bus command 2 and the line becomes Modified. A local write of an Exclusive line becomes Modified with no bus command.
- R5: A local eviction (`req_op` 2) leaves any line Invalid. Only an eviction from Modified raises `wb_valid`, with `wb_idx` equal to the line. An eviction of an Invalid line produces no output.
- R6: A local read of a Shared, Exclusive or Modified line, and a local write of a Modified line, issue no bus command and leave the state unchanged.
- R7: Any snooped command on an Invalid line produces no response, no writeback, no error and no state change.
- R8: A snooped read (`snp_cmd` 0) has these effects:
  - on Shared: raises `resp_shared` and the line stays Shared;
  - on Exclusive: raises `resp_shared` and the line moves to Shared;
  - on Modified: raises `resp_dirty` and `wb_valid` and the line moves to Shared.
- R9: A snooped write (`snp_cmd` 1) invalidates a Shared or Exclusive line silently. On a Modified line it raises `wb_valid` and `resp_dirty` and the line becomes Invalid.
- R10: A snooped upgrade (`snp_cmd` 2) invalidates a Shared line. On an Exclusive or Modified line it raises `err_illegal` and leaves the state unchanged.
- R11: `req_ready` is 0 whenever `snp_valid` is 1. The snoop is handled in that cycle. A request held during the stall is taken in the first cycle after `snp_valid` falls.
- R12: An event on one line leaves the state of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Local request can be taken this cycle |
| req_op | input | 2 | Local operation: 0 read, 1 write, 2 evict |
| req_idx | input | IDX_W | Line targeted by the local request |
| req_shared | input | 1 | Another cache holds the line (sampled on a read miss) |
| snp_valid | input | 1 | Snooped bus command present |
| snp_cmd | input | 2 | Snooped command: 0 read, 1 write, 2 upgrade |
| snp_idx | input | IDX_W | Line targeted by the snoop |
| bus_valid | output | 1 | Outgoing bus command present |
| bus_cmd | output | 2 | Outgoing command: 0 read, 1 write, 2 upgrade |
| bus_idx | output | IDX_W | Line of the outgoing command |
| resp_shared | output | 1 | Shared snoop response |
| resp_dirty | output | 1 | Dirty snoop response |
| wb_valid | output | 1 | Writeback request |
| wb_idx | output | IDX_W | Line to write back |
| err_illegal | output | 1 | Illegal snoop detected |
| look_idx | input | IDX_W | Line to look up |
| look_state | output | 2 | Current state of line `look_idx` |

## Verification
The bench runs every combination of the following on every line:

- each of the four starting states, built through the block's own request port;
- each of the seven events, where the local read is tried with the sharing input both low and high.

The two sharing values separate the Exclusive and Shared fill paths. The starting states separate a silent upgrade from a bus upgrade, and a plain invalidation from one that needs a writeback. Before each event a neighbouring line is set to a different state, which shows whether an update leaks to another index. A local write that collides with a snoop shows that the snoop wins the cycle and that the stalled request completes afterwards.

// File: rtl/mesi_coh_pkg.sv
package mesi_coh_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    LOP_RD  = 2'd0,
    LOP_WR  = 2'd1,
    LOP_EV  = 2'd2,
    LOP_NOP = 2'd3
  } loc_op_t;

  typedef enum logic [1:0] {
    SN_RD  = 2'd0,
    SN_WR  = 2'd1,
    SN_UPG = 2'd2,
    SN_NOP = 2'd3
  } snp_op_t;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_WR  = 2'd1,
    BC_UPG = 2'd2,
    BC_RSV = 2'd3
  } bus_op_t;

  // Outcome of one coherence event on one line
  typedef struct packed {
    line_st_t nxt;
    logic     bus_go;
    bus_op_t  bus_op;
    logic     wb;
    logic     shr;
    logic     dty;
    logic     err;
  } coh_act_t;

endpackage

// File: rtl/mesi_local_fsm.sv
module mesi_local_fsm
  import mesi_coh_pkg::*;
(
  input  line_st_t cur,
  input  loc_op_t  op,
  input  logic     shared_in,
  output coh_act_t act
);

  always_comb begin
    act        = '0;
    act.nxt    = cur;
    act.bus_op = BC_RD;
    unique case (op)
      LOP_RD: begin
        if (cur == ST_I) begin
          act.bus_go = 1'b1;
          act.bus_op = BC_RD;
          act.nxt    = shared_in ? ST_S : ST_E;
        end
      end
      LOP_WR: begin
        unique case (cur)
          ST_I: begin
            act.bus_go = 1'b1;
            act.bus_op = BC_WR;
            act.nxt    = ST_M;
          end
          ST_S: begin
            act.bus_go = 1'b1;
            act.bus_op = BC_UPG;
            act.nxt    = ST_M;
          end
          ST_E: act.nxt = ST_M;
          default: act.nxt = cur;
        endcase
      end
      LOP_EV: begin
        act.wb  = (cur == ST_M);
        act.nxt = ST_I;
      end
      default: act.nxt = cur;
    endcase
  end

endmodule

// File: rtl/mesi_snoop_fsm.sv
module mesi_snoop_fsm
  import mesi_coh_pkg::*;
(
  input  line_st_t cur,
  input  snp_op_t  op,
  output coh_act_t act
);

  always_comb begin
    act        = '0;
    act.nxt    = cur;
    act.bus_op = BC_RD;
    unique case (op)
      SN_RD: begin
        unique case (cur)
          ST_S: act.shr = 1'b1;
          ST_E: begin
            act.shr = 1'b1;
            act.nxt = ST_S;
          end
          ST_M: begin
            act.wb  = 1'b1;
            act.dty = 1'b1;
            act.nxt = ST_S;
          end
          default: act.nxt = cur;
        endcase
      end
      SN_WR: begin
        unique case (cur)
          ST_S, ST_E: act.nxt = ST_I;
          ST_M: begin
            act.wb  = 1'b1;
            act.dty = 1'b1;
            act.nxt = ST_I;
          end
          default: act.nxt = cur;
        endcase
      end
      SN_UPG: begin
        unique case (cur)
          ST_S:       act.nxt = ST_I;
          ST_E, ST_M: act.err = 1'b1;
          default:    act.nxt = cur;
        endcase
      end
      default: act.nxt = cur;
    endcase
  end

endmodule

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  line_st_t         wst,
  input  logic [IDX_W-1:0] ridx_a,
  output line_st_t         rst_a,
  input  logic [IDX_W-1:0] ridx_b,
  output line_st_t         rst_b
);

  line_st_t st_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)                                  st_q[g] <= ST_I;
      else if (we && (widx == IDX_W'(g)))          st_q[g] <= wst;
    end
  end

  assign rst_a = st_q[ridx_a];
  assign rst_b = st_q[ridx_b];

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_shared,
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             bus_valid,
  output logic [1:0]       bus_cmd,
  output logic [IDX_W-1:0] bus_idx,
  output logic             resp_shared,
  output logic             resp_dirty,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic             err_illegal,
  input  logic [IDX_W-1:0] look_idx,
  output logic [1:0]       look_state
);

  logic             req_fire;
  logic [IDX_W-1:0] ev_idx;
  line_st_t         ev_st;
  line_st_t         lk_st;
  coh_act_t         loc_act;
  coh_act_t         snp_act;
  coh_act_t         sel_act;
  logic             ev_we;

  // Snoops cannot wait, so they own the line array in their cycle
  assign req_ready = !snp_valid;
  assign req_fire  = req_valid && req_ready;
  assign ev_idx    = snp_valid ? snp_idx : req_idx;
  assign ev_we     = snp_valid || req_fire;

  mesi_line_array #(
    .NUM_LINES(NUM_LINES),
    .IDX_W    (IDX_W)
  ) u_lines (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ev_we),
    .widx  (ev_idx),
    .wst   (sel_act.nxt),
    .ridx_a(ev_idx),
    .rst_a (ev_st),
    .ridx_b(look_idx),
    .rst_b (lk_st)
  );

  mesi_local_fsm u_local (
    .cur      (ev_st),
    .op       (loc_op_t'(req_op)),
    .shared_in(req_shared),
    .act      (loc_act)
  );

  mesi_snoop_fsm u_snoop (
    .cur(ev_st),
    .op (snp_op_t'(snp_cmd)),
    .act(snp_act)
  );

  always_comb begin
    if (snp_valid)     sel_act = snp_act;
    else if (req_fire) sel_act = loc_act;
    else begin
      sel_act     = '0;
      sel_act.nxt = ev_st;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid   <= 1'b0;
      bus_cmd     <= 2'd0;
      bus_idx     <= '0;
      resp_shared <= 1'b0;
      resp_dirty  <= 1'b0;
      wb_valid    <= 1'b0;
      wb_idx      <= '0;
      err_illegal <= 1'b0;
    end else begin
      bus_valid   <= !snp_valid && req_fire && loc_act.bus_go;
      bus_cmd     <= sel_act.bus_op;
      bus_idx     <= ev_idx;
      resp_shared <= snp_valid && snp_act.shr;
      resp_dirty  <= snp_valid && snp_act.dty;
      wb_valid    <= ev_we && sel_act.wb;
      wb_idx      <= ev_idx;
      err_illegal <= snp_valid && snp_act.err;
    end
  end

  assign look_state = lk_st;

  // A snoop cycle never launches a bus command of our own
  p_snoop_blocks_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !bus_valid);

  // Errors come only from a snooped upgrade
  p_err_from_upgrade_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |-> ($past(snp_valid) && $past(snp_cmd) == 2'd2));

  // Dirty response always goes with a writeback
  p_dirty_with_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_dirty |-> wb_valid);

  // Shared and dirty responses are exclusive
  p_resp_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_shared && resp_dirty));

  // An upgrade on the bus results only from a local write
  p_upgrade_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == 2'd2) |-> ($past(req_op) == 2'd1));

endmodule

// File: tb/test_mesi_snoop_ctrl.sv
module test_mesi_snoop_ctrl;
  localparam int NL    = 4;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             req_valid, req_ready, req_shared;
  logic [1:0]       req_op;
  logic [IDX_W-1:0] req_idx;
  logic             snp_valid;
  logic [1:0]       snp_cmd;
  logic [IDX_W-1:0] snp_idx;
  logic             bus_valid, resp_shared, resp_dirty, wb_valid, err_illegal;
  logic [1:0]       bus_cmd, look_state;
  logic [IDX_W-1:0] bus_idx, wb_idx, look_idx;

  mesi_snoop_ctrl #(.NUM_LINES(NL)) i_mesi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_idx(req_idx), .req_shared(req_shared),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
    .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_idx(bus_idx),
    .resp_shared(resp_shared), .resp_dirty(resp_dirty),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .err_illegal(err_illegal),
    .look_idx(look_idx), .look_state(look_state)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  int c_bv, c_bc, c_bi, c_wb, c_wi, c_sh, c_dt, c_er;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic capture();
    c_bv = bus_valid; c_bc = bus_cmd; c_bi = bus_idx;
    c_wb = wb_valid;  c_wi = wb_idx;  c_sh = resp_shared;
    c_dt = resp_dirty; c_er = err_illegal;
  endtask

  task automatic peek(int idx, output int s);
    look_idx = idx[IDX_W-1:0];
    #1;
    s = look_state;
  endtask

  task automatic local_ev(int op, int idx, int shr);
    @(negedge clk);
    req_valid = 1'b1; req_op = op[1:0];
    req_idx = idx[IDX_W-1:0]; req_shared = shr[0];
    @(negedge clk);
    capture();
    req_valid = 1'b0;
  endtask

  task automatic snoop_ev(int cmd, int idx);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd[1:0]; snp_idx = idx[IDX_W-1:0];
    @(negedge clk);
    capture();
    snp_valid = 1'b0;
  endtask

  // states: 0 I, 1 S, 2 E, 3 M
  task automatic set_state(int idx, int st);
    local_ev(2, idx, 0);
    case (st)
      1: local_ev(0, idx, 1);
      2: local_ev(0, idx, 0);
      3: local_ev(1, idx, 0);
      default: ;
    endcase
  endtask

  // events: 0 read/no sharer, 1 read/sharer, 2 write, 3 evict,
  //         4 snoop read, 5 snoop write, 6 snoop upgrade
  task automatic apply(int ev, int idx);
    case (ev)
      0: local_ev(0, idx, 0);
      1: local_ev(0, idx, 1);
      2: local_ev(1, idx, 0);
      3: local_ev(2, idx, 0);
      4: snoop_ev(0, idx);
      5: snoop_ev(1, idx);
      default: snoop_ev(2, idx);
    endcase
  endtask

  task automatic model(int st, int ev, output int nst, output int bv, output int bc,
                       output int wb, output int sh, output int dt, output int er);
    nst = st; bv = 0; bc = 0; wb = 0; sh = 0; dt = 0; er = 0;
    case (ev)
      0, 1: if (st == 0) begin bv = 1; bc = 0; nst = (ev == 1) ? 1 : 2; end
      2: begin
        if (st == 0) begin bv = 1; bc = 1; end
        if (st == 1) begin bv = 1; bc = 2; end
        nst = 3;
      end
      3: begin wb = (st == 3); nst = 0; end
      4: begin
        if (st == 1 || st == 2) begin sh = 1; nst = 1; end
        if (st == 3) begin wb = 1; dt = 1; nst = 1; end
      end
      5: begin
        if (st == 3) begin wb = 1; dt = 1; end
        nst = 0;
      end
      default: begin
        if (st == 1) nst = 0;
        if (st >= 2) er = 1;
      end
    endcase
  endtask

  function automatic string tag_of(int st, int ev);
    if (ev >= 4 && st == 0) return "R7";
    case (ev)
      0, 1: return (st == 0) ? "R2" : "R6";
      2: return (st == 0) ? "R3" : (st == 3) ? "R6" : "R4";
      3: return "R5";
      4: return "R8";
      5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    int s;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_idx = '0; req_shared = 1'b0;
    snp_valid = 1'b0; snp_cmd = 2'd0; snp_idx = '0; look_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < NL; i++) begin
      peek(i, s);
      chk("R1 state", s, 0);
    end
    chk("R1 bus_valid", bus_valid, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 responses", resp_shared | resp_dirty, 0);
    chk("R1 err", err_illegal, 0);

    // Sweep every start state and event on every line
    for (int idx = 0; idx < NL; idx++) begin
      for (int st = 0; st < 4; st++) begin
        for (int ev = 0; ev < 7; ev++) begin
          int nb, nb_st, nst, bv, bc, wb, sh, dt, er;
          string t;
          nb    = (idx + 1) % NL;
          nb_st = (st + ev + 1) % 4;
          set_state(nb, nb_st);
          set_state(idx, st);
          apply(ev, idx);
          model(st, ev, nst, bv, bc, wb, sh, dt, er);
          t = tag_of(st, ev);
          chk({t, " bus_valid"}, c_bv, bv);
          if (bv != 0) begin
            chk({t, " bus_cmd"}, c_bc, bc);
            chk({t, " bus_idx"}, c_bi, idx);
          end
          chk({t, " wb_valid"}, c_wb, wb);
          if (wb != 0) chk({t, " wb_idx"}, c_wi, idx);
          chk({t, " resp_shared"}, c_sh, sh);
          chk({t, " resp_dirty"}, c_dt, dt);
          chk({t, " err"}, c_er, er);
          peek(idx, s);
          chk({t, " next state"}, s, nst);
          peek(nb, s);
          chk("R12 neighbour state", s, nb_st);
        end
      end
    end

    // R11: local write collides with a snoop on the same Invalid line
    set_state(2, 0);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'd0; snp_idx = 2'd2;
    req_valid = 1'b1; req_op = 2'd1; req_idx = 2'd2; req_shared = 1'b0;
    #1;
    chk("R11 ready low under snoop", req_ready, 0);
    @(negedge clk);
    capture();
    chk("R11 no bus cmd in snoop cycle", c_bv, 0);
    chk("R11 no response for Invalid", c_sh | c_dt, 0);
    snp_valid = 1'b0;
    #1;
    chk("R11 ready back", req_ready, 1);
    @(negedge clk);
    capture();
    req_valid = 1'b0;
    chk("R11 stalled write issued", c_bv, 1);
    chk("R11 stalled write cmd", c_bc, 1);
    peek(2, s);
    chk("R11 stalled write state", s, 3);

    finish_run();
  end

endmodule